// File: doc/BRIEF.md
# Double-Buffered PWM Timer Channel

This block is one pulse-width modulation channel built around a 16-bit down-counter. The clock first passes through an 8-bit prescaler and then a power-of-two divider. Each resulting step moves the counter down by one. The main output is high while the count is at or below a compare value, so the compare value sets the duty cycle and the reload value sets the period.

New period and compare values are first written into holding registers. They are copied into the working counter and comparator only when a run starts or when the counter passes zero, so a write never cuts a cycle short. The channel either runs continuously or stops after one period. Each pass through zero sets a sticky flag, and that flag, gated by an enable, drives an interrupt request.

With the pair mode on, a second output carries the complement of the first. Both rising edges are held back by a programmable dead time, so the two outputs are never high together. Clearing the run input returns the channel to idle with both outputs low.

Top module: `pwm_timer_channel`

## Requirements
- R1: After reset, both PWM outputs, the flag, the interrupt request and the count output are all 0.
- R2: The counter takes one step every (prescale+1)·2^k clock cycles. Here k equals div_sel for div_sel 0 to 4, which gives ratios 1, 2, 4, 8 and 16. The codes 5, 6 and 7 act as 16.
- R3: On start the count loads the buffered period. It then falls by one per step. At the step after 0 it reloads the buffered period, so one PWM cycle lasts period+1 steps.
- R4: A period or compare write changes nothing in the cycle under way. The new value takes effect at the next start or at the reload after 0.
- R5: In one-shot mode (one_shot=1) the counter stays at 0 after its first pass through zero. Both outputs then stay low and the flag is not set again. This holds until run is cleared and set once more, which starts a fresh cycle.
- R6: pwm_a is high while count ≤ compare and low while count > compare. It lags the count output by one clock. Per cycle that gives (min(compare, period)+1) high steps, so any compare ≥ period gives 100% duty.
- R7: The flag is set on the step taken while the count is 0. A one-cycle pulse on flag_clr clears it. A set in the same cycle wins over the clear.
- R8: irq equals flag AND the value of int_en one clock earlier.
- R9: With dz_en=1, pwm_b follows the complement of the level behind pwm_a. The rising edge of each output is delayed by dead_time·(prescale+1) clock cycles. The two outputs are never high together.
- R10: With dz_en=0, pwm_b stays low and pwm_a rises with no dead-time delay.
- R11: Two clocks after run is cleared, both outputs are low and the count reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Level: 1 runs the channel, 0 idles it |
| one_shot | input | 1 | 1 = stop after a single cycle, 0 = continuous |
| dz_en | input | 1 | Enables the complementary pair with dead time |
| prescale | input | 8 | Prescaler divide value minus one |
| div_sel | input | 3 | Divider select (0..4 → 1,2,4,8,16; 5..7 → 16) |
| dead_time | input | 8 | Dead time in prescaled clocks |
| int_en | input | 1 | Interrupt enable |
| per_wr | input | 1 | Write strobe for the period buffer |
| per_din | input | 16 | Period value |
| cmp_wr | input | 1 | Write strobe for the compare buffer |
| cmp_din | input | 16 | Compare value |
| flag_clr | input | 1 | Write-one-to-clear pulse for the flag |
| pwm_a | output | 1 | Main PWM output |
| pwm_b | output | 1 | Complementary output (pair mode only) |
| count | output | 16 | Current down-counter value |
| flag | output | 1 | Zero-reached flag |
| irq | output | 1 | Interrupt request |

## Verification
High time is counted over one whole PWM cycle in steady state. Random period, compare, prescale, divider and dead-time settings are mixed with directed settings: compare 0, compare at or above the period, and divider codes above 4. These separate an off-by-one in the comparison, a wrong step length and a wrong dead-time delay. Writes made in the middle of a cycle show whether the holding registers wait for the zero point. A one-shot run followed by a restart, and a stop in mid-cycle, check the end-of-run behaviour. Toggling the interrupt enable and the clear pulse around a set flag checks the request gating.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } run_state_e;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int PRE_W     = 8,
  parameter int SEL_W     = 3,
  parameter int MAX_SHIFT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [PRE_W-1:0] prescale,
  input  logic [SEL_W-1:0] div_sel,
  output logic             pre_tick,
  output logic             step_tick
);
  localparam int DIV_W = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_mask;
  int               sel_i;
  int               shift_amt;

  // clamp the select code to the deepest divider stage
  always_comb begin
    sel_i = int'(div_sel);
    shift_amt = (sel_i > MAX_SHIFT) ? MAX_SHIFT : sel_i;
    for (int i = 0; i < DIV_W; i++) begin
      div_mask[i] = (i < shift_amt);
    end
  end

  assign pre_tick  = enable && (pre_cnt == prescale);
  assign step_tick = pre_tick && ((div_cnt & div_mask) == div_mask);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (pre_tick) begin
      pre_cnt <= '0;
      div_cnt <= div_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_period_core.sv
module pwm_period_core
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             one_shot,
  input  logic             step,
  input  logic             per_wr,
  input  logic [CNT_W-1:0] per_din,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_din,
  input  logic             flag_clr,
  input  logic             int_en,
  output logic [CNT_W-1:0] count,
  output logic             active,
  output logic             raw_hi,
  output logic             flag,
  output logic             irq,
  output run_state_e       state
);
  run_state_e       st_q;
  logic [CNT_W-1:0] per_buf, cmp_buf, cnt_q, cmp_act;
  logic             flag_q, irq_q;
  logic             at_zero, zero_hit, flag_nxt;

  assign at_zero  = (cnt_q == '0);
  assign zero_hit = (st_q == ST_RUN) && run && step && at_zero;
  assign flag_nxt = zero_hit | (flag_q & ~flag_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      per_buf <= '0;
      cmp_buf <= '0;
      cnt_q   <= '0;
      cmp_act <= '0;
      flag_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (per_wr) per_buf <= per_din;
      if (cmp_wr) cmp_buf <= cmp_din;
      flag_q <= flag_nxt;
      irq_q  <= flag_nxt & int_en;
      unique case (st_q)
        ST_IDLE: begin
          if (run) begin
            cnt_q   <= per_buf;
            cmp_act <= cmp_buf;
            st_q    <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (!run) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
          end else if (step) begin
            if (at_zero) begin
              if (one_shot) begin
                st_q <= ST_DONE;
              end else begin
                cnt_q   <= per_buf;
                cmp_act <= cmp_buf;
              end
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
        end
        ST_DONE: begin
          if (!run) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign active = (st_q == ST_RUN);
  assign raw_hi = active && (cnt_q <= cmp_act);
  assign count  = cnt_q;
  assign flag   = flag_q;
  assign irq    = irq_q;
  assign state  = st_q;
endmodule

// File: rtl/pwm_dead_band.sv
module pwm_dead_band #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pre_tick,
  input  logic            dz_en,
  input  logic            active,
  input  logic            raw_hi,
  input  logic [DT_W-1:0] dead_time,
  output logic            out_a,
  output logic            out_b
);
  localparam int LANES = 2;

  logic [LANES-1:0] want;
  logic [DT_W-1:0]  dt_eff;

  assign want[0] = active & raw_hi;
  assign want[1] = dz_en & active & ~raw_hi;
  assign dt_eff  = dz_en ? dead_time : '0;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DT_W-1:0] dly;
    logic            o;
    always_ff @(posedge clk) begin
      if (rst || !want[g]) begin
        dly <= '0;
        o   <= 1'b0;
      end else if (dly >= dt_eff) begin
        o <= 1'b1;
      end else if (pre_tick) begin
        dly <= dly + 1'b1;
      end
    end
  end

  assign out_a = g_lane[0].o;
  assign out_b = g_lane[1].o;
endmodule

// File: rtl/pwm_timer_channel.sv
module pwm_timer_channel
  import pwm_timer_pkg::*;
#(
  parameter int PRE_W     = 8,
  parameter int SEL_W     = 3,
  parameter int MAX_SHIFT = 4,
  parameter int CNT_W     = 16,
  parameter int DT_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             one_shot,
  input  logic             dz_en,
  input  logic [PRE_W-1:0] prescale,
  input  logic [SEL_W-1:0] div_sel,
  input  logic [DT_W-1:0]  dead_time,
  input  logic             int_en,
  input  logic             per_wr,
  input  logic [CNT_W-1:0] per_din,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_din,
  input  logic             flag_clr,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic [CNT_W-1:0] count,
  output logic             flag,
  output logic             irq
);
  logic       pre_tick, step_tick;
  logic       core_active, core_raw;
  run_state_e core_st;

  pwm_tick_gen #(
    .PRE_W(PRE_W), .SEL_W(SEL_W), .MAX_SHIFT(MAX_SHIFT)
  ) u_tick (
    .clk(clk), .rst(rst), .enable(run), .prescale(prescale),
    .div_sel(div_sel), .pre_tick(pre_tick), .step_tick(step_tick)
  );

  pwm_period_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .run(run), .one_shot(one_shot), .step(step_tick),
    .per_wr(per_wr), .per_din(per_din), .cmp_wr(cmp_wr), .cmp_din(cmp_din),
    .flag_clr(flag_clr), .int_en(int_en), .count(count),
    .active(core_active), .raw_hi(core_raw), .flag(flag), .irq(irq),
    .state(core_st)
  );

  pwm_dead_band #(.DT_W(DT_W)) u_dead (
    .clk(clk), .rst(rst), .pre_tick(pre_tick), .dz_en(dz_en),
    .active(core_active), .raw_hi(core_raw), .dead_time(dead_time),
    .out_a(pwm_a), .out_b(pwm_b)
  );
endmodule

// File: rtl/pwm_timer_channel_chk.sv
module pwm_timer_channel_chk
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             int_en,
  input logic             dz_en,
  input logic             pwm_a,
  input logic             pwm_b,
  input logic [CNT_W-1:0] count,
  input logic             flag,
  input logic             irq,
  input run_state_e       st
);
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(pwm_a && pwm_b));

  a_r8_irq_gate: assert property (@(posedge clk) disable iff (rst)
    irq == (flag && $past(int_en)));

  a_r7_flag_at_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> ($past(count) == '0));

  a_r3_step_or_reload: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && $past(st) == ST_RUN && count != $past(count))
      |-> ((count + 1'b1) == $past(count) || $past(count) == '0));

  a_r5_oneshot_hold: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DONE && $past(st) == ST_DONE)
      |-> (count == '0 && !pwm_a && !pwm_b && !$rose(flag)));

  a_r11_stopped_quiet: assert property (@(posedge clk) disable iff (rst)
    (!$past(run) && !$past(run, 2)) |-> (!pwm_a && !pwm_b && count == '0));

  a_r10_single_ended: assert property (@(posedge clk) disable iff (rst)
    !$past(dz_en) |-> !pwm_b);
endmodule

bind pwm_timer_channel pwm_timer_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .run(run), .int_en(int_en), .dz_en(dz_en),
  .pwm_a(pwm_a), .pwm_b(pwm_b), .count(count), .flag(flag), .irq(irq),
  .st(core_st)
);

// File: tb/tb_pwm_timer_channel.sv
module tb_pwm_timer_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0, one_shot = 1'b0, dz_en = 1'b0, int_en = 1'b0;
  logic [7:0]  prescale = '0, dead_time = '0;
  logic [2:0]  div_sel = '0;
  logic        per_wr = 1'b0, cmp_wr = 1'b0, flag_clr = 1'b0;
  logic [15:0] per_din = '0, cmp_din = '0;
  logic        pwm_a, pwm_b, flag, irq;
  logic [15:0] count;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pwm_timer_channel dut (
    .clk(clk), .rst(rst), .run(run), .one_shot(one_shot), .dz_en(dz_en),
    .prescale(prescale), .div_sel(div_sel), .dead_time(dead_time),
    .int_en(int_en), .per_wr(per_wr), .per_din(per_din), .cmp_wr(cmp_wr),
    .cmp_din(cmp_din), .flag_clr(flag_clr), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .count(count), .flag(flag), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int step_len(input int p, input int d);
    int ds = (d > 4) ? 4 : d;
    return (p + 1) << ds;
  endfunction

  function automatic int exp_hi_a(input int per, input int cmp, input int p,
                                  input int d, input bit dz, input int dt);
    int t = step_len(p, d);
    int h;
    if (cmp >= per) return (per + 1) * t;
    h = (cmp + 1) * t - (dz ? dt * (p + 1) : 0);
    return (h > 0) ? h : 0;
  endfunction

  function automatic int exp_hi_b(input int per, input int cmp, input int p,
                                  input int d, input bit dz, input int dt);
    int t = step_len(p, d);
    int l;
    if (!dz || cmp >= per) return 0;
    l = (per - cmp) * t - dt * (p + 1);
    return (l > 0) ? l : 0;
  endfunction

  task automatic start_cfg(input int per, input int cmp, input int p, input int d,
                           input bit os, input bit dz, input int dt);
    @(negedge clk);
    run = 1'b0;
    repeat (3) @(negedge clk);
    prescale = 8'(p); div_sel = 3'(d); one_shot = os; dz_en = dz;
    dead_time = 8'(dt);
    per_wr = 1'b1; per_din = 16'(per);
    cmp_wr = 1'b1; cmp_din = 16'(cmp);
    flag_clr = 1'b1;
    @(negedge clk);
    per_wr = 1'b0; cmp_wr = 1'b0; flag_clr = 1'b0;
    run = 1'b1;
  endtask

  task automatic measure(input int n, output int ha, output int hb);
    ha = 0; hb = 0;
    repeat (n) begin
      @(negedge clk);
      ha += int'(pwm_a);
      hb += int'(pwm_b);
    end
  endtask

  task automatic wait_count(input int v);
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (int'(count) != v && guard < 5000);
  endtask

  initial begin
    #(20 * 190000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int ha, hb, w, rises, mx, lows;
    bit prev;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pwm_a", int'(pwm_a), 0);
    chk("R1 pwm_b", int'(pwm_b), 0);
    chk("R1 flag", int'(flag), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 count", int'(count), 0);

    // R6 R10 basic duty, single-ended
    start_cfg(19, 4, 0, 0, 1'b0, 1'b0, 0);
    repeat (30) @(negedge clk);
    measure(20, ha, hb);
    chk("R6 duty 5/20", ha, 5);
    chk("R10 pwm_b low", hb, 0);

    // R6 compare 0 and compare above period
    start_cfg(9, 0, 0, 0, 1'b0, 1'b0, 0);
    repeat (15) @(negedge clk);
    measure(10, ha, hb);
    chk("R6 compare zero", ha, 1);
    start_cfg(9, 30, 0, 0, 1'b0, 1'b0, 0);
    repeat (15) @(negedge clk);
    measure(10, ha, hb);
    chk("R6 full duty", ha, 10);

    // R2 divider code above 4 acts as 16
    start_cfg(3, 1, 1, 7, 1'b0, 1'b0, 0);
    repeat (200) @(negedge clk);
    measure(128, ha, hb);
    chk("R2 clamp duty", ha, 64);
    begin
      int v0, len;
      v0 = int'(count);
      do @(negedge clk); while (int'(count) == v0);
      v0 = int'(count);
      len = 0;
      do begin @(negedge clk); len++; end while (int'(count) == v0);
      chk("R2 step length", len, 32);
    end

    // R4 R3 period shadow
    start_cfg(20, 5, 0, 0, 1'b0, 1'b0, 0);
    wait_count(10);
    per_wr = 1'b1; per_din = 16'd50;
    @(negedge clk);
    per_wr = 1'b0;
    mx = int'(count);
    while (count != 0) begin
      @(negedge clk);
      if (int'(count) > mx) mx = int'(count);
    end
    chk("R4 old period kept", mx, 9);
    @(negedge clk);
    chk("R4 new period at reload", int'(count), 50);
    @(negedge clk);
    chk("R3 counts down", int'(count), 49);

    // R4 compare shadow
    start_cfg(30, 25, 0, 0, 1'b0, 1'b0, 0);
    wait_count(20);
    cmp_wr = 1'b1; cmp_din = 16'd5;
    lows = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i == 0) cmp_wr = 1'b0;
      if (!pwm_a) lows++;
    end
    chk("R4 old compare kept", lows, 0);
    chk("R3 reached zero", int'(count), 0);
    repeat (2) @(negedge clk);
    chk("R4 new compare applied", int'(pwm_a), 0);

    // R5 R7 one-shot
    start_cfg(15, 6, 0, 0, 1'b1, 1'b0, 0);
    ha = 0; rises = 0; prev = flag;
    repeat (60) begin
      @(negedge clk);
      ha += int'(pwm_a);
      if (flag && !prev) rises++;
      prev = flag;
    end
    chk("R5 one-shot high time", ha, 7);
    chk("R5 single flag", rises, 1);
    chk("R5 parked at zero", int'(count), 0);
    chk("R7 flag set", int'(flag), 1);

    // R8 irq gating, R7 clear
    chk("R8 irq masked", int'(irq), 0);
    int_en = 1'b1;
    @(negedge clk);
    chk("R8 irq raised", int'(irq), 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R7 flag cleared", int'(flag), 0);
    chk("R8 irq dropped", int'(irq), 0);
    int_en = 1'b0;

    // R5 re-arm by toggling run
    run = 1'b0;
    repeat (2) @(negedge clk);
    run = 1'b1;
    repeat (30) @(negedge clk);
    chk("R5 re-arm sets flag", int'(flag), 1);

    // R9 dead time directed
    start_cfg(39, 19, 0, 0, 1'b0, 1'b1, 3);
    repeat (50) @(negedge clk);
    measure(40, ha, hb);
    chk("R9 pwm_a high", ha, 17);
    chk("R9 pwm_b high", hb, 17);

    // R11 stop mid-run
    start_cfg(19, 19, 0, 0, 1'b0, 1'b0, 0);
    repeat (30) @(negedge clk);
    chk("R11 running high", int'(pwm_a), 1);
    run = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 pwm_a low", int'(pwm_a), 0);
    chk("R11 pwm_b low", int'(pwm_b), 0);
    chk("R11 count zero", int'(count), 0);

    // R2 R6 R9 random settings
    for (int k = 0; k < 8; k++) begin
      int per, cmp, p, d, dt;
      bit dz;
      per = 3 + int'($urandom_range(37));
      cmp = int'($urandom_range(per + 4));
      p = int'($urandom_range(3));
      d = int'($urandom_range(7));
      dz = 1'($urandom_range(1));
      dt = int'($urandom_range(6));
      start_cfg(per, cmp, p, d, 1'b0, dz, dt);
      w = (per + 1) * step_len(p, d);
      repeat (w + 10) @(negedge clk);
      measure(w, ha, hb);
      chk("R6 R2 random pwm_a", ha, exp_hi_a(per, cmp, p, d, dz, dt));
      chk("R9 random pwm_b", hb, exp_hi_b(per, cmp, p, d, dz, dt));
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule